// File: doc/BRIEF.md
# I2C High-Speed Mode Entry Tracker

This block listens to an I2C bus from the slave side and follows the speed mode the bus is in. It runs on a system clock that is much faster than SCL and oversamples both bus lines. Both lines pass through synchronisers before any edge is detected. The block finds START, repeated START and STOP conditions. After a START from an idle bus, it assembles the first byte and compares it with the reserved high-speed master code (top five bits `00001`, low three bits ignored).

After a matching code, the block tells the local slave to leave SDA released for the acknowledge slot. It then watches the ninth bit. If SDA is high in that slot, the bus has entered high-speed mode, and the mode flag stays set across any number of repeated STARTs and transfers. If SDA is low, entry is abandoned. Any STOP returns the tracker to fast/standard mode and idle. Address matching, data movement and analog filtering are handled elsewhere; the slave logic uses the flag to select its high-speed timing.

Top module: `i2cHsTracker`

## Requirements
- R1: SDA falling while SCL is high is a START. It produces a one-cycle `startPulse` three clock cycles after the pin edge (two synchroniser flops plus one register) and sets `busBusy`. A START seen while the bus is already busy also pulses `rstartPulse` in the same cycle. `startPulse` and `stopPulse` are never high together.
- R2: SDA rising while SCL is high is a STOP. It produces a one-cycle `stopPulse` and clears `busBusy`.
- R3: The first byte after a START from an idle bus is sampled MSB first, one bit at each SCL rising edge. A STOP earlier in that byte restarts the alignment. If the byte ANDed with 0xF8 equals 0x08, `holdRelease` is high from the rising edge that completes the byte until the ninth SCL rising edge. Otherwise `holdRelease` stays low.
- R4: After a matching code, SDA high at the ninth SCL rising edge sets `hsMode`.
- R5: After a matching code, SDA low at the ninth SCL rising edge abandons entry, and `hsMode` stays low.
- R6: Once set, `hsMode` stays high through repeated STARTs and the address and data bytes that follow them.
- R7: A STOP clears `hsMode` in the same cycle that `stopPulse` is raised.
- R8: A byte after a repeated START is never checked for the master code, whether the bus is in fast/standard or high-speed mode. `holdRelease` stays low and `hsMode` does not change.
- R9: While reset is asserted and after it is released, `hsMode`, `busBusy`, `holdRelease` and all three pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Raw SCL level from the pad |
| sdaIn | input | 1 | Raw SDA level from the pad |
| hsMode | output | 1 | High while the bus is in high-speed mode |
| busBusy | output | 1 | High between a START and the next STOP |
| startPulse | output | 1 | One-cycle pulse for every START or repeated START |
| rstartPulse | output | 1 | One-cycle pulse for a START seen while busy |
| stopPulse | output | 1 | One-cycle pulse for a STOP |
| holdRelease | output | 1 | The slave must not acknowledge; keep SDA released |

## Verification
Two kinds of state error show up quickly at the ports. A bit counter that has slipped out of step either misses the master code or flags a non-code byte, and this is seen at `holdRelease` right after the eighth SCL rise of the first byte. A tracking state that does not survive repeated STARTs, or that fails to reset on STOP, shows on `hsMode` within three clock cycles of the bus event concerned. The bench checks each output level shortly after every byte, ninth bit and bus condition. It also counts the condition pulses over a whole transaction, so a lost or extra pulse is caught within that transaction.

// File: rtl/i2cHsPkg.sv
package i2cHsPkg;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  // events from the datapath, valid for one cycle
  typedef struct packed {
    logic start;
    logic stop;
    logic byteDone;
    logic ninthBit;
    logic codeMatch;
    logic sdaLevel;
  } busEvt_t;

  // strobes from the control into the datapath
  typedef struct packed {
    logic clrCount;
  } ctrlStrb_t;

  typedef enum logic [2:0] {
    sIdle,
    sFirstByte,
    sCodeAck,
    sFsBusy,
    sHsBusy
  } trkState_t;
endpackage

// File: rtl/i2cHsDatapath.sv
module i2cHsDatapath
  import i2cHsPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_BITS-1:0] CODE_VALUE = 8'h08,
  parameter logic [BYTE_BITS-1:0] CODE_MASK = 8'hF8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  ctrlStrb_t ctrl,
  output busEvt_t   evt
);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(BYTE_BITS);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclNow, sdaNow, sclRise;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_BITS-1:0] shiftReg, shiftNext;

  // synchroniser chain, idle bus level is high
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : gSync
    if (i == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe[0] <= 1'b1;
          sdaPipe[0] <= 1'b1;
        end else begin
          sclPipe[0] <= sclIn;
          sdaPipe[0] <= sdaIn;
        end
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe[i] <= 1'b1;
          sdaPipe[i] <= 1'b1;
        end else begin
          sclPipe[i] <= sclPipe[i-1];
          sdaPipe[i] <= sdaPipe[i-1];
        end
      end
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclRise = sclNow && !sclPrev;

  // bit position within the current byte, 0..BYTE_BITS
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clrCount) begin
      bitCnt <= '0;
    end else if (sclRise) begin
      bitCnt <= (bitCnt == ACK_IDX) ? '0 : bitCnt + 1'b1;
    end
  end

  assign shiftNext = {shiftReg[BYTE_BITS-2:0], sdaNow};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (sclRise) begin
      shiftReg <= shiftNext;
    end
  end

  always_comb begin
    evt.start     = sclNow && sclPrev && sdaPrev && !sdaNow;
    evt.stop      = sclNow && sclPrev && !sdaPrev && sdaNow;
    evt.byteDone  = sclRise && (bitCnt == LAST_DATA);
    evt.ninthBit  = sclRise && (bitCnt == ACK_IDX);
    evt.codeMatch = (shiftNext & CODE_MASK) == CODE_VALUE;
    evt.sdaLevel  = sdaNow;
  end

  // byte alignment restarts after every clear request
  assert_count_cleared_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrCount |=> (bitCnt == '0));
endmodule

// File: rtl/i2cHsControl.sv
module i2cHsControl
  import i2cHsPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  busEvt_t   evt,
  output ctrlStrb_t ctrl,
  output logic      hsMode,
  output logic      busBusy,
  output logic      startPulse,
  output logic      rstartPulse,
  output logic      stopPulse,
  output logic      holdRelease
);
  trkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (evt.stop) begin
      stateNext = sIdle;
    end else if (evt.start) begin
      case (state)
        sIdle:   stateNext = sFirstByte;
        sHsBusy: stateNext = sHsBusy;
        default: stateNext = sFsBusy;
      endcase
    end else begin
      case (state)
        sFirstByte: if (evt.byteDone) stateNext = evt.codeMatch ? sCodeAck : sFsBusy;
        sCodeAck:   if (evt.ninthBit) stateNext = evt.sdaLevel ? sHsBusy : sFsBusy;
        default:    stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= sIdle;
      startPulse  <= 1'b0;
      rstartPulse <= 1'b0;
      stopPulse   <= 1'b0;
    end else begin
      state       <= stateNext;
      startPulse  <= evt.start;
      rstartPulse <= evt.start && (state != sIdle);
      stopPulse   <= evt.stop;
    end
  end

  assign ctrl.clrCount = evt.start || evt.stop;
  assign hsMode      = (state == sHsBusy);
  assign busBusy     = (state != sIdle);
  assign holdRelease = (state == sCodeAck);

  assert_pulses_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startPulse, stopPulse}));
  assert_hold_after_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdRelease) |-> $past(evt.byteDone && evt.codeMatch));
  assert_entry_needs_nack_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsMode) |-> $past(evt.ninthBit && evt.sdaLevel));
  assert_rstart_keeps_hs_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hsMode && evt.start) |=> hsMode);
  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    evt.stop |=> (!hsMode && !busBusy && stopPulse));
endmodule

// File: rtl/i2cHsTracker.sv
module i2cHsTracker
  import i2cHsPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_BITS-1:0] CODE_VALUE = 8'h08,
  parameter logic [BYTE_BITS-1:0] CODE_MASK = 8'hF8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic hsMode,
  output logic busBusy,
  output logic startPulse,
  output logic rstartPulse,
  output logic stopPulse,
  output logic holdRelease
);
  busEvt_t   evt;
  ctrlStrb_t ctrl;

  i2cHsDatapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .CODE_VALUE (CODE_VALUE),
    .CODE_MASK  (CODE_MASK)
  ) uData (
    .clk  (clk),
    .rstN (rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .ctrl (ctrl),
    .evt  (evt)
  );

  i2cHsControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .evt        (evt),
    .ctrl       (ctrl),
    .hsMode     (hsMode),
    .busBusy    (busBusy),
    .startPulse (startPulse),
    .rstartPulse(rstartPulse),
    .stopPulse  (stopPulse),
    .holdRelease(holdRelease)
  );
endmodule

// File: tb/tb_i2cHsTracker.sv
`timescale 1ns/1ps
module tb_i2cHsTracker;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic hsMode, busBusy, startPulse, rstartPulse, stopPulse, holdRelease;

  int checks = 0;
  int fails = 0;
  int startCnt = 0, rstartCnt = 0, stopCnt = 0;
  bit holdSeen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2cHsTracker dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaDrv),
    .hsMode(hsMode), .busBusy(busBusy), .startPulse(startPulse),
    .rstartPulse(rstartPulse), .stopPulse(stopPulse), .holdRelease(holdRelease)
  );

  always @(negedge clk) begin
    if (rstN) begin
      startCnt  += int'(startPulse);
      rstartCnt += int'(rstartPulse);
      stopCnt   += int'(stopPulse);
      if (holdRelease) holdSeen = 1;
    end
  end

  // byte[10:3], ninth bit[2], expected holdRelease[1], expected hsMode[0]
  localparam logic [10:0] VEC [7] = '{
    {8'h08, 1'b1, 1'b1, 1'b1},
    {8'h0F, 1'b1, 1'b1, 1'b1},
    {8'h0C, 1'b0, 1'b1, 1'b0},
    {8'h18, 1'b1, 1'b0, 1'b0},
    {8'h88, 1'b1, 1'b0, 1'b0},
    {8'h07, 1'b1, 1'b0, 1'b0},
    {8'h0B, 1'b1, 1'b1, 1'b1}
  };

  task automatic waitQ(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ(Q);
    sclDrv = 1'b1; waitQ(Q);
    sdaDrv = 1'b0; waitQ(Q);
    sclDrv = 1'b0; waitQ(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ(Q);
    sclDrv = 1'b1; waitQ(Q);
    sdaDrv = 1'b1; waitQ(Q);
  endtask

  task automatic busBit(logic b);
    sdaDrv = b;    waitQ(Q);
    sclDrv = 1'b1; waitQ(2 * Q);
    sclDrv = 1'b0; waitQ(Q);
  endtask

  task automatic busByte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) busBit(v[i]);
  endtask

  task automatic doReset();
    rstN = 1'b0; sclDrv = 1'b1; sdaDrv = 1'b1;
    waitQ(5);
    rstN = 1'b1;
    waitQ(Q);
  endtask

  initial begin
    doReset();
    // R9: reset state
    chk("R9 hsMode", int'(hsMode), 0);
    chk("R9 busBusy", int'(busBusy), 0);
    chk("R9 holdRelease", int'(holdRelease), 0);
    chk("R9 pulses", startCnt + stopCnt + rstartCnt, 0);

    // table walk: entry, abort, non-code, persistence, stop
    for (int r = 0; r < 7; r++) begin
      logic [7:0] b;
      b = VEC[r][10:3];
      busStart();
      chk("R1 busBusy after start", int'(busBusy), 1);
      busByte(b);
      chk("R3 holdRelease after byte", int'(holdRelease), int'(VEC[r][1]));
      busBit(VEC[r][2]);
      chk("R4/R5 hsMode after ninth bit", int'(hsMode), int'(VEC[r][0]));
      chk("R3 holdRelease cleared", int'(holdRelease), 0);
      busStart();
      busByte(8'hA1); busBit(1'b0);
      busByte(8'h5A); busBit(1'b1);
      chk("R6 hsMode across Sr", int'(hsMode), int'(VEC[r][0]));
      busStop();
      chk("R7 hsMode after stop", int'(hsMode), 0);
      chk("R2 busBusy after stop", int'(busBusy), 0);
    end

    // R1/R2 pulse counts over one transaction
    startCnt = 0; rstartCnt = 0; stopCnt = 0;
    busStart(); busByte(8'hA0); busBit(1'b0);
    busStart(); busByte(8'hA1); busBit(1'b0);
    busStop();
    chk("R1 start pulses", startCnt, 2);
    chk("R1 rstart pulses", rstartCnt, 1);
    chk("R2 stop pulses", stopCnt, 1);

    // R1 pulse latency: three clocks after SDA falls
    sdaDrv = 1'b1; sclDrv = 1'b1; waitQ(Q);
    startCnt = 0;
    sdaDrv = 1'b0; waitQ(2);
    chk("R1 no pulse before third clock", startCnt, 0);
    waitQ(2);
    chk("R1 pulse by fourth clock", startCnt, 1);
    sclDrv = 1'b0; waitQ(Q);
    busStop();

    // R8: master code after Sr in fast/standard mode
    holdSeen = 0;
    busStart(); busByte(8'hA0); busBit(1'b0);
    busStart(); busByte(8'h08);
    chk("R8 no hold after Sr in FS", int'(holdSeen), 0);
    busBit(1'b1);
    chk("R8 no entry after Sr in FS", int'(hsMode), 0);
    busStop();

    // R8/R6: master code after Sr while in high-speed mode
    busStart(); busByte(8'h08); busBit(1'b1);
    holdSeen = 0;
    busStart(); busByte(8'h08);
    chk("R8 no hold after Sr in HS", int'(holdSeen), 0);
    busBit(1'b0);
    chk("R6 hsMode kept after Sr code", int'(hsMode), 1);
    busStart(); busStart();
    chk("R6 hsMode after several Sr", int'(hsMode), 1);
    busStop();
    chk("R7 stop leaves HS", int'(hsMode), 0);

    // R3: STOP in the middle of the first byte realigns the next byte
    busStart(); busBit(1'b0); busBit(1'b0); busBit(1'b0);
    busStop();
    chk("R2 idle after short frame", int'(busBusy), 0);
    busStart(); busByte(8'h09);
    chk("R3 code found after realign", int'(holdRelease), 1);
    busBit(1'b1);
    chk("R4 entry after realign", int'(hsMode), 1);

    // R9: reset while in high-speed mode
    doReset();
    chk("R9 hsMode after reset", int'(hsMode), 0);
    chk("R9 busBusy after reset", int'(busBusy), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule